// File: doc/BRIEF.md
# Unsolicited Reply Sequencer and Line Encoder

This block drives the reply stream that a low-frequency transponder sends on its own, without waiting for a reader command. Three packed configuration inputs pick the behaviour at runtime. One input selects the line code. One selects the bit rate. One selects which pages are sent, and one value of that field switches unsolicited replies off completely. When the block is enabled and a page range is selected, it reads 32-bit pages through a page-read port in ascending address order. It shifts each page out most significant bit first and line-codes every bit into two equal half-bit levels on a single modulation output.

All timing is counted in cycles of the carrier-clock enable, a one-cycle pulse that marks each period of the 125 kHz carrier. The block does nothing on system clocks that carry no such pulse. A busy output is high for exactly the duration of a frame. While the enable input stays high, a new frame follows each one after a fixed idle gap. The configuration is captured when a frame starts, so changes during a frame take effect only in the next one.

Top module: `ttf_reply_tx`

## Requirements
- R1: After reset, `mod_out` and `busy` are 0 and `page_addr` holds the first page address (4).
- R2: With `cfg_range` = 00, no frame starts: `busy` and `mod_out` stay 0 regardless of `tx_enable`.
- R3: `cfg_range` = 01 sends pages 4 and 5, 10 sends pages 4, 5, 6 and 7, and 11 sends page 4 only, in ascending address order and back to back.
- R4: Each page is sent most significant bit (bit 31) first.
- R5: With `cfg_line_code` = 0 (Manchester), a 1 is sent as a high half followed by a low half, and a 0 as a low half followed by a high half.
- R6: With `cfg_line_code` = 1 (biphase), the level inverts at the start of every bit and inverts again at mid-bit only for a 0. The line idles low, so the first half of a frame is high.
- R7: The half-bit length in carrier ticks is 16 for `cfg_rate` = 00, 8 for 01, and 32 for both 10 and 11.
- R8: `busy` is high from the tick that starts the first half-bit until the tick that ends the last one, and `mod_out` is 0 whenever `busy` is 0.
- R9: With `tx_enable` held high, the next frame starts on the carrier tick that comes 41 ticks (gap of 40 plus one) after `busy` falls. If `tx_enable` falls during a frame, that frame completes and no new one starts.
- R10: Line code, rate and page range are sampled on the tick that starts a frame. Changes during the frame do not alter it.
- R11: Outputs and internal progress change only on clock edges where `carrier_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier_tick | input | 1 | One-cycle pulse per carrier period |
| tx_enable | input | 1 | Permits unsolicited frames while high |
| cfg_line_code | input | 1 | 0 Manchester, 1 biphase |
| cfg_rate | input | 2 | Bit-rate select (see R7) |
| cfg_range | input | 2 | Page-range select, 00 disables (see R3) |
| page_addr | output | 6 | Address of the page to be read next |
| page_data | input | 32 | Page contents at `page_addr`, combinational |
| mod_out | output | 1 | Line-coded modulation level |
| busy | output | 1 | High while a frame is being sent |

## Verification
Two events can fall on the same carrier tick. At a page boundary, fetching the next page and ending the last bit of the current one happen together. On the tick that starts a frame, the configuration is captured while the configuration inputs may be about to change. The bench checks every half-bit level of frames spanning one, two and four pages. This shows that the first bit of each new page appears without a lost or repeated bit. It also randomizes all three configuration fields right after a frame starts and requires the frame to match the settings sampled at the start. A carrier pause in mid-frame is added to show that nothing advances between ticks.

// File: rtl/ttf_pkg.sv
package ttf_pkg;

    typedef enum logic {
        LC_MANCHESTER = 1'b0,
        LC_BIPHASE    = 1'b1
    } line_code_e;

    typedef enum logic [1:0] {
        RATE_MID  = 2'b00,
        RATE_FAST = 2'b01,
        RATE_SLOW = 2'b10,
        RATE_ALT  = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        RANGE_OFF  = 2'b00,
        RANGE_TWO  = 2'b01,
        RANGE_FOUR = 2'b10,
        RANGE_ONE  = 2'b11
    } range_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'b00,
        SQ_SEND = 2'b01,
        SQ_GAP  = 2'b10
    } seq_state_e;

    typedef struct packed {
        line_code_e code;
        rate_e      rate;
        range_e     range;
    } tx_cfg_t;

    typedef struct packed {
        logic frame_start;
        logic bit_start;
        logic mid_bit;
        logic stop;
        logic bit_val;
    } enc_ctrl_t;

    localparam int unsigned MAX_PAGES = 4;

    function automatic int unsigned range_pages(range_e r);
        case (r)
            RANGE_TWO:  return 2;
            RANGE_FOUR: return 4;
            RANGE_ONE:  return 1;
            default:    return 0;
        endcase
    endfunction

    function automatic int unsigned rate_half(rate_e r, int unsigned base);
        case (r)
            RATE_FAST: return base / 2;
            RATE_MID:  return base;
            default:   return base * 2;
        endcase
    endfunction

endpackage

// File: rtl/ttf_halfbit_timer.sv
module ttf_halfbit_timer #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic [CNT_W-1:0] half_len,
    output logic             half_done
);

    logic [CNT_W-1:0] cnt;

    assign half_done = tick && run && (cnt == half_len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            if (half_done || !run) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_CNT_BELOW_HALF: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < half_len)); // R7

endmodule

// File: rtl/ttf_frame_seq.sv
module ttf_frame_seq
    import ttf_pkg::*;
#(
    parameter int unsigned PAGE_W     = 32,
    parameter int unsigned ADDR_W     = 6,
    parameter int unsigned FIRST_PAGE = 4,
    parameter int unsigned GAP_TICKS  = 40,
    parameter int unsigned BASE_HALF  = 16,
    localparam int unsigned CNT_W     = $clog2(2 * BASE_HALF + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              enable,
    input  tx_cfg_t           cfg_in,
    input  logic [PAGE_W-1:0] page_data,
    input  logic              half_done,
    output logic [ADDR_W-1:0] page_addr,
    output logic [CNT_W-1:0]  half_len,
    output logic              run,
    output logic              busy,
    output line_code_e        code_now,
    output enc_ctrl_t         ctrl
);

    localparam int unsigned BIT_W = $clog2(PAGE_W);
    localparam int unsigned PL_W  = $clog2(MAX_PAGES);
    localparam int unsigned GAP_W = $clog2(GAP_TICKS + 1);

    seq_state_e        state;
    line_code_e        code_q;
    rate_e             rate_q;
    logic [PAGE_W-2:0] rest_bits;
    logic [BIT_W-1:0]  bits_left;
    logic [PL_W-1:0]   pages_left;
    logic              second_half;
    logic [GAP_W-1:0]  gap_cnt;
    logic [ADDR_W-1:0] addr;

    logic start_ok, bit_end, more_bits, more_pages;

    assign start_ok   = tick && (state == SQ_IDLE) && enable && (cfg_in.range != RANGE_OFF);
    assign bit_end    = half_done && second_half;
    assign more_bits  = (bits_left != '0);
    assign more_pages = (pages_left != '0);

    always_comb begin
        ctrl.frame_start = start_ok;
        ctrl.mid_bit     = half_done && !second_half;
        ctrl.bit_start   = start_ok || (bit_end && (more_bits || more_pages));
        ctrl.stop        = bit_end && !more_bits && !more_pages;
        if (start_ok || (bit_end && !more_bits)) begin
            ctrl.bit_val = page_data[PAGE_W-1];
        end else begin
            ctrl.bit_val = rest_bits[PAGE_W-2];
        end
    end

    assign code_now  = (state == SQ_IDLE) ? cfg_in.code : code_q;
    assign half_len  = CNT_W'(rate_half(rate_q, BASE_HALF));
    assign run       = (state == SQ_SEND);
    assign busy      = (state == SQ_SEND);
    assign page_addr = addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SQ_IDLE;
            code_q      <= LC_MANCHESTER;
            rate_q      <= RATE_MID;
            rest_bits   <= '0;
            bits_left   <= '0;
            pages_left  <= '0;
            second_half <= 1'b0;
            gap_cnt     <= '0;
            addr        <= ADDR_W'(FIRST_PAGE);
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start_ok) begin
                        code_q      <= cfg_in.code;
                        rate_q      <= cfg_in.rate;
                        rest_bits   <= page_data[PAGE_W-2:0];
                        addr        <= addr + 1'b1;
                        pages_left  <= PL_W'(range_pages(cfg_in.range) - 1);
                        bits_left   <= BIT_W'(PAGE_W - 1);
                        second_half <= 1'b0;
                        state       <= SQ_SEND;
                    end
                end
                SQ_SEND: begin
                    if (half_done) begin
                        if (!second_half) begin
                            second_half <= 1'b1;
                        end else begin
                            second_half <= 1'b0;
                            if (more_bits) begin
                                rest_bits <= {rest_bits[PAGE_W-3:0], 1'b0};
                                bits_left <= bits_left - 1'b1;
                            end else if (more_pages) begin
                                rest_bits  <= page_data[PAGE_W-2:0];
                                addr       <= addr + 1'b1;
                                pages_left <= pages_left - 1'b1;
                                bits_left  <= BIT_W'(PAGE_W - 1);
                            end else begin
                                state   <= SQ_GAP;
                                gap_cnt <= '0;
                                addr    <= ADDR_W'(FIRST_PAGE);
                            end
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (gap_cnt == GAP_W'(GAP_TICKS - 1)) begin
                            gap_cnt <= '0;
                            state   <= SQ_IDLE;
                        end else begin
                            gap_cnt <= gap_cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (page_addr >= ADDR_W'(FIRST_PAGE)) && (page_addr <= ADDR_W'(FIRST_PAGE + MAX_PAGES))); // R3

    AST_OFF_NO_START: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE && cfg_in.range == RANGE_OFF) |=> (state == SQ_IDLE)); // R2

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_SEND) |=> ($stable(code_q) && $stable(rate_q))); // R10

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_GAP) |-> (gap_cnt < GAP_W'(GAP_TICKS))); // R9

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(state) && $stable(addr) && $stable(bits_left))); // R11

endmodule

// File: rtl/ttf_line_coder.sv
module ttf_line_coder
    import ttf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_code_e code,
    input  enc_ctrl_t  ctrl,
    output logic       level
);

    logic bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
            bit_q <= 1'b0;
        end else begin
            if (ctrl.bit_start) begin
                bit_q <= ctrl.bit_val;
            end
            if (ctrl.stop) begin
                level <= 1'b0;
            end else if (ctrl.bit_start) begin
                if (code == LC_MANCHESTER) begin
                    level <= ctrl.bit_val;
                end else begin
                    level <= ctrl.frame_start ? 1'b1 : ~level;
                end
            end else if (ctrl.mid_bit) begin
                if (code == LC_MANCHESTER) begin
                    level <= ~bit_q;
                end else if (!bit_q) begin
                    level <= ~level;
                end
            end
        end
    end

    AST_MANCH_MID_FLIP: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mid_bit && code == LC_MANCHESTER) |=> (level != $past(level))); // R5

    AST_BP_BOUNDARY_FLIP: assert property (@(posedge clk) disable iff (rst)
        (ctrl.bit_start && code == LC_BIPHASE) |=> (level != $past(level))); // R6

endmodule

// File: rtl/ttf_reply_tx.sv
module ttf_reply_tx
    import ttf_pkg::*;
#(
    parameter int unsigned PAGE_W     = 32,
    parameter int unsigned ADDR_W     = 6,
    parameter int unsigned FIRST_PAGE = 4,
    parameter int unsigned GAP_TICKS  = 40,
    parameter int unsigned BASE_HALF  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              carrier_tick,
    input  logic              tx_enable,
    input  logic              cfg_line_code,
    input  logic [1:0]        cfg_rate,
    input  logic [1:0]        cfg_range,
    output logic [ADDR_W-1:0] page_addr,
    input  logic [PAGE_W-1:0] page_data,
    output logic              mod_out,
    output logic              busy
);

    localparam int unsigned CNT_W = $clog2(2 * BASE_HALF + 1);

    tx_cfg_t          cfg_in;
    logic [CNT_W-1:0] half_len;
    logic             run, half_done;
    line_code_e       code_now;
    enc_ctrl_t        ctrl;

    assign cfg_in = '{code:  line_code_e'(cfg_line_code),
                      rate:  rate_e'(cfg_rate),
                      range: range_e'(cfg_range)};

    ttf_frame_seq #(
        .PAGE_W     (PAGE_W),
        .ADDR_W     (ADDR_W),
        .FIRST_PAGE (FIRST_PAGE),
        .GAP_TICKS  (GAP_TICKS),
        .BASE_HALF  (BASE_HALF)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (carrier_tick),
        .enable    (tx_enable),
        .cfg_in    (cfg_in),
        .page_data (page_data),
        .half_done (half_done),
        .page_addr (page_addr),
        .half_len  (half_len),
        .run       (run),
        .busy      (busy),
        .code_now  (code_now),
        .ctrl      (ctrl)
    );

    ttf_halfbit_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick      (carrier_tick),
        .run       (run),
        .half_len  (half_len),
        .half_done (half_done)
    );

    ttf_line_coder u_coder (
        .clk   (clk),
        .rst   (rst),
        .code  (code_now),
        .ctrl  (ctrl),
        .level (mod_out)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mod_out); // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !carrier_tick |=> ($stable(mod_out) && $stable(busy))); // R11

endmodule

// File: tb/ttf_reply_tx_tb.sv
module ttf_reply_tx_tb;

    localparam int PAGE_W     = 32;
    localparam int ADDR_W     = 6;
    localparam int FIRST_PAGE = 4;
    localparam int GAP_TICKS  = 40;
    localparam int BASE_HALF  = 16;
    localparam int TICK_DIV   = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              carrier_tick = 1'b0;
    logic              tick_on = 1'b1;
    logic              tx_enable = 1'b0;
    logic              cfg_line_code = 1'b0;
    logic [1:0]        cfg_rate = 2'b00;
    logic [1:0]        cfg_range = 2'b00;
    logic [ADDR_W-1:0] page_addr;
    logic [PAGE_W-1:0] page_data;
    logic              mod_out, busy;
    logic [PAGE_W-1:0] mem [0:(1<<ADDR_W)-1];

    int n_checks = 0;
    int n_fail   = 0;
    int phase    = 0;

    always #2 clk = ~clk;

    assign page_data = mem[page_addr];

    ttf_reply_tx #(
        .PAGE_W     (PAGE_W),
        .ADDR_W     (ADDR_W),
        .FIRST_PAGE (FIRST_PAGE),
        .GAP_TICKS  (GAP_TICKS),
        .BASE_HALF  (BASE_HALF)
    ) u_dut (
        .clk           (clk),
        .rst           (rst),
        .carrier_tick  (carrier_tick),
        .tx_enable     (tx_enable),
        .cfg_line_code (cfg_line_code),
        .cfg_rate      (cfg_rate),
        .cfg_range     (cfg_range),
        .page_addr     (page_addr),
        .page_data     (page_data),
        .mod_out       (mod_out),
        .busy          (busy)
    );

    initial begin : tick_gen
        forever begin
            @(negedge clk);
            carrier_tick <= (tick_on && phase == 0);
            phase = (phase + 1) % TICK_DIV;
        end
    end

    function automatic int exp_half(input logic [1:0] rate);
        case (rate)
            2'b00:   return BASE_HALF;
            2'b01:   return BASE_HALF / 2;
            default: return BASE_HALF * 2;
        endcase
    endfunction

    function automatic int exp_pages(input logic [1:0] range);
        case (range)
            2'b01:   return 2;
            2'b10:   return 4;
            2'b11:   return 1;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic step_tick();
        do @(posedge clk); while (carrier_tick !== 1'b1);
        @(negedge clk);
    endtask

    task automatic capture_frame(input logic code, input logic [1:0] rate,
                                 input logic [1:0] range, input bit scramble,
                                 input bit drop_en, input bit pause);
        int h;
        int nb;
        int waited;
        int total_bad;
        bit prev;
        h = exp_half(rate);
        nb = exp_pages(range) * PAGE_W;
        waited = 0;
        total_bad = 0;
        prev = 1'b0;
        while (busy !== 1'b1 && waited < 200) begin
            step_tick();
            waited++;
        end
        check(busy === 1'b1, "R9", "frame start seen", int'(busy), 1);
        if (busy !== 1'b1) return;
        for (int b = 0; b < nb; b++) begin
            logic [PAGE_W-1:0] w;
            bit v, lv0, lv1;
            w = mem[FIRST_PAGE + b / PAGE_W];
            v = w[PAGE_W-1 - (b % PAGE_W)];
            if (code == 1'b0) begin
                lv0 = v;
                lv1 = !v;
            end else begin
                lv0 = !prev;
                lv1 = v ? lv0 : !lv0;
            end
            prev = lv1;
            for (int s = 0; s < 2; s++) begin
                bit e;
                int bad;
                int got;
                e = (s == 0) ? lv0 : lv1;
                bad = 0;
                got = int'(mod_out);
                for (int t = 0; t < h; t++) begin
                    if (mod_out !== e || busy !== 1'b1) begin
                        bad++;
                        got = int'(mod_out);
                    end
                    if (b == 0 && s == 1 && t == 0) begin
                        if (scramble) {cfg_line_code, cfg_rate, cfg_range} = 5'($urandom);
                        if (drop_en) tx_enable = 1'b0;
                    end
                    if (pause && b == 2 && s == 0 && t == 1) begin
                        logic m0, b0;
                        int moved;
                        m0 = mod_out;
                        b0 = busy;
                        moved = 0;
                        tick_on = 1'b0;
                        repeat (40) begin
                            @(negedge clk);
                            if (mod_out !== m0 || busy !== b0) moved++;
                        end
                        check(moved == 0, "R11", "outputs held without carrier", moved, 0);
                        tick_on = 1'b1;
                    end
                    step_tick();
                end
                total_bad += bad;
                if (code == 1'b0)
                    check(bad == 0, "R3 R4 R5 R7", "Manchester half level", got, int'(e));
                else
                    check(bad == 0, "R3 R4 R6 R7", "biphase half level", got, int'(e));
            end
        end
        if (scramble)
            check(total_bad == 0, "R10", "frame kept captured config", total_bad, 0);
    endtask

    task automatic after_frame(input bit expect_restart);
        check(busy === 1'b0 && mod_out === 1'b0, "R8", "line quiet after last half",
              int'({busy, mod_out}), 0);
        if (expect_restart) begin
            int n;
            n = 0;
            while (busy !== 1'b1 && n < GAP_TICKS + 50) begin
                step_tick();
                if (busy !== 1'b1 && mod_out !== 1'b0) n += 1000;
                n++;
            end
            check(n == GAP_TICKS + 1, "R9", "ticks from busy fall to next start", n, GAP_TICKS + 1);
        end else begin
            int hits;
            hits = 0;
            for (int i = 0; i < GAP_TICKS + 20; i++) begin
                step_tick();
                if (busy !== 1'b0 || mod_out !== 1'b0) hits++;
            end
            check(hits == 0, "R9", "no restart after enable drop", hits, 0);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
        finish_run();
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = $urandom;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(mod_out === 1'b0, "R1", "mod_out after reset", int'(mod_out), 0);
        check(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
        check(page_addr === ADDR_W'(FIRST_PAGE), "R1", "page_addr after reset",
              int'(page_addr), FIRST_PAGE);

        // R2: range 00 disables replies even with enable high
        begin
            int hits;
            hits = 0;
            cfg_range = 2'b00;
            tx_enable = 1'b1;
            for (int i = 0; i < 100; i++) begin
                step_tick();
                if (busy !== 1'b0 || mod_out !== 1'b0 || page_addr !== ADDR_W'(FIRST_PAGE)) hits++;
            end
            check(hits == 0, "R2", "activity with range off", hits, 0);
            tx_enable = 1'b0;
        end

        // Manchester, fast rate, one page, two frames back to back (R9 repeat)
        cfg_line_code = 1'b0; cfg_rate = 2'b01; cfg_range = 2'b11; tx_enable = 1'b1;
        capture_frame(1'b0, 2'b01, 2'b11, 1'b0, 1'b0, 1'b0);
        after_frame(1'b1);
        capture_frame(1'b0, 2'b01, 2'b11, 1'b0, 1'b1, 1'b0);
        after_frame(1'b0);

        // Biphase, mid rate, two pages, with a carrier pause (R11)
        cfg_line_code = 1'b1; cfg_rate = 2'b00; cfg_range = 2'b01; tx_enable = 1'b1;
        capture_frame(1'b1, 2'b00, 2'b01, 1'b0, 1'b1, 1'b1);
        after_frame(1'b0);

        // Manchester, slow rate, four pages, config scrambled mid-frame (R10)
        cfg_line_code = 1'b0; cfg_rate = 2'b10; cfg_range = 2'b10; tx_enable = 1'b1;
        capture_frame(1'b0, 2'b10, 2'b10, 1'b1, 1'b1, 1'b0);
        after_frame(1'b0);

        // Biphase, alternate slow code, one page with long runs of 0 and 1
        mem[FIRST_PAGE] = 32'h0000_FFFF;
        cfg_line_code = 1'b1; cfg_rate = 2'b11; cfg_range = 2'b11; tx_enable = 1'b1;
        capture_frame(1'b1, 2'b11, 2'b11, 1'b0, 1'b1, 1'b0);
        after_frame(1'b0);

        // Random frames with fresh page contents
        for (int k = 0; k < 4; k++) begin
            logic c;
            logic [1:0] r, g;
            for (int i = FIRST_PAGE; i < FIRST_PAGE + 4; i++) mem[i] = $urandom;
            c = 1'($urandom);
            r = 2'($urandom % 2);
            g = 2'(1 + $urandom % 3);
            cfg_line_code = c; cfg_rate = r; cfg_range = g; tx_enable = 1'b1;
            capture_frame(c, r, g, 1'b1, 1'b1, 1'b0);
            after_frame(1'b0);
        end

        finish_run();
    end

endmodule